// File: doc/BRIEF.md
# PC Card Host Bus Byte-Lane Front End

This block sits on the card side of a 16-bit PC card host bus, serving memory-card and I/O-card operation. Each cycle it looks at the space-select line, the two chip-enable lines, address bit 0, and the four host strobes: memory read, memory write, I/O read and I/O write. From these it picks a lane mode and a target. The target is either a 256-byte attribute space, or an eight-register task file that the host can reach through the I/O strobes or the memory strobes.

On a read, the block places the addressed 8-bit values on the low lane, the high lane or both, and raises the matching lane drive enable. The pad logic outside the block uses those enables to build the tri-state buffers. On a write, it records the address and data while the strobe is low. When the strobe returns high it commits them to the attribute bytes or to the task-file registers. The lower part of the attribute space holds fixed card information that the host cannot overwrite. The host strobes are assumed to be already synchronised to `clk`.

Top module: `pcbus_lane_front`

## Requirements
- R1: With both chip enables high (standby), both lane enables are 0 and no write is committed, whatever the strobes do.
- R2: Byte mode (`cs_lo_n`=0, `cs_hi_n`=1): a read drives only the low lane (bits 7:0); `addr[0]` selects the even or odd byte.
- R3: Word mode (both chip enables low): a read drives both lanes, even byte on bits 7:0 and odd byte on bits 15:8; `addr[0]` has no effect.
- R4: Odd-byte mode (`cs_lo_n`=1, `cs_hi_n`=0): a read drives only the high lane (bits 15:8) with the odd byte; a write stores only `hd_in[15:8]` into the odd byte.
- R5: Attribute access is `spc_n`=0 with the memory strobes, I/O strobes high. Attribute byte k sits at host address 2k. Odd-address byte reads and every high-lane attribute read return `INV_BYTE` (0xFF). Odd-address and odd-byte-mode attribute writes change nothing.
- R6: Attribute bytes 0 to `CIS_BYTES`-1 (0..127) are read-only and reset to (3k+0x11) mod 256; writes to them are ignored. Bytes from `CIS_BYTES` upward reset to 0 and are writable through the even lane.
- R7: I/O-mapped task-file access is `spc_n`=0 with `io_rd_n`/`io_wr_n`, memory strobes high.
- R8: Memory-mapped task-file access is `spc_n`=1 with `mem_rd_n`/`mem_wr_n`, I/O strobes high, and reaches the same registers as I/O mapping.
- R9: The task-file index in byte mode is `addr[2:0]`. Word mode uses the pair {`addr[2:1]`,0} (low lane) and {`addr[2:1]`,1} (high lane). Odd-byte mode uses {`addr[2:1]`,1}. All registers reset to 0.
- R10: A write commits at the first clock edge that samples its strobe high after sampling it low. It uses the address and data sampled in the last low cycle, and a strobe pulse commits exactly once.
- R11: Any strobe clash leaves both lanes disabled and commits nothing. A clash is a memory strobe together with an I/O strobe, or a read strobe together with a write strobe of the same kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| spc_n | input | 1 | Space select: 0 attribute/I-O space, 1 common memory |
| cs_lo_n | input | 1 | Low chip enable, active low |
| cs_hi_n | input | 1 | High chip enable, active low |
| addr | input | ADDR_W (9) | Host address, bit 0 is the byte select |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| hd_in | input | 16 | Host write data |
| hd_out | output | 16 | Read data toward the pads |
| lane_lo_en | output | 1 | Drive enable for bits 7:0 |
| lane_hi_en | output | 1 | Drive enable for bits 15:8 |

## Verification
The bench builds the block with its default parameters. These are 256 attribute bytes with a 128-byte protected region, eight task-file registers and an invalid-lane value of 0xFF. With these values, the last protected byte (127) and a writable byte above the boundary (200) can both be reached with short address values. Every task-file register, every even/odd pair and every one of the four lane modes can be driven directly from the table of vectors. The directed part then covers the write paths through both mappings, writes into protected and odd-address attribute bytes, standby and clash writes, and data that changes while the strobe is held low.

// File: rtl/pcbus_pkg.sv
package pcbus_pkg;

    typedef enum logic [1:0] {
        LM_STANDBY = 2'd0,
        LM_BYTE    = 2'd1,
        LM_WORD    = 2'd2,
        LM_ODD     = 2'd3
    } lane_mode_e;

    typedef enum logic [1:0] {
        TG_NONE   = 2'd0,
        TG_ATTR   = 2'd1,
        TG_TF_IO  = 2'd2,
        TG_TF_MEM = 2'd3
    } target_e;

    typedef struct packed {
        target_e    tgt;
        lane_mode_e mode;
        logic       rd;
        logic       wr;
    } access_t;

    function automatic lane_mode_e mode_of(input logic hi_n, input logic lo_n);
        case ({hi_n, lo_n})
            2'b10:   return LM_BYTE;
            2'b00:   return LM_WORD;
            2'b01:   return LM_ODD;
            default: return LM_STANDBY;
        endcase
    endfunction

    function automatic logic [7:0] cis_seed(input int unsigned k);
        return 8'((k * 3 + 32'h11) & 32'hFF);
    endfunction

endpackage

// File: rtl/pcbus_decode.sv
module pcbus_decode
    import pcbus_pkg::*;
(
    input  logic    spc_n,
    input  logic    cs_lo_n,
    input  logic    cs_hi_n,
    input  logic    mem_rd_n,
    input  logic    mem_wr_n,
    input  logic    io_rd_n,
    input  logic    io_wr_n,
    output access_t acc
);
    logic mem_any, io_any, clash;
    lane_mode_e mode;

    always_comb begin
        mode    = mode_of(cs_hi_n, cs_lo_n);
        mem_any = !mem_rd_n || !mem_wr_n;
        io_any  = !io_rd_n || !io_wr_n;
        clash   = (mem_any && io_any)
                || (!mem_rd_n && !mem_wr_n)
                || (!io_rd_n && !io_wr_n);

        acc      = '0;
        acc.mode = mode;
        if (mode != LM_STANDBY && !clash) begin
            if (io_any && !spc_n)
                acc.tgt = TG_TF_IO;
            else if (mem_any)
                acc.tgt = spc_n ? TG_TF_MEM : TG_ATTR;
        end
        acc.rd = (acc.tgt != TG_NONE) && (!mem_rd_n || !io_rd_n);
        acc.wr = (acc.tgt != TG_NONE) && (!mem_wr_n || !io_wr_n);
    end
endmodule

// File: rtl/pcbus_attr_space.sv
module pcbus_attr_space
    import pcbus_pkg::*;
#(
    parameter int ATTR_BYTES = 256,
    parameter int CIS_BYTES  = 128,
    parameter int IW         = $clog2(ATTR_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] ridx,
    output logic [7:0]    rdata
);
    localparam logic [IW:0] CIS_LIM = CIS_BYTES[IW:0];

    logic [7:0] mem [ATTR_BYTES];
    logic       writable;

    assign writable = {1'b0, widx} >= CIS_LIM;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ATTR_BYTES; i++)
                mem[i] <= (i < CIS_BYTES) ? cis_seed(i) : 8'h00;
        end else if (we && writable) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];

    generate
        if (CIS_BYTES > 0) begin : g_cis_chk
            // R6: protected bytes never move after reset
            a_r6_cis_first_frozen: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> $stable(mem[0]));
            a_r6_cis_last_frozen: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> $stable(mem[CIS_BYTES-1]));
        end
    endgenerate
endmodule

// File: rtl/pcbus_taskfile.sv
module pcbus_taskfile #(
    parameter int TF_REGS = 8,
    parameter int IW      = $clog2(TF_REGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_lo,
    input  logic [IW-1:0] widx_lo,
    input  logic [7:0]    wd_lo,
    input  logic          we_hi,
    input  logic [IW-1:0] widx_hi,
    input  logic [7:0]    wd_hi,
    input  logic [IW-1:0] ridx_lo,
    input  logic [IW-1:0] ridx_hi,
    output logic [7:0]    rd_lo,
    output logic [7:0]    rd_hi
);
    logic [7:0] regs [TF_REGS];

    for (genvar g = 0; g < TF_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= 8'h00;
            else if (we_lo && widx_lo == IW'(g))
                regs[g] <= wd_lo;
            else if (we_hi && widx_hi == IW'(g))
                regs[g] <= wd_hi;
        end
    end

    assign rd_lo = regs[ridx_lo];
    assign rd_hi = regs[ridx_hi];

    // R9: the two write ports never aim at the same register together
    a_r9_ports_disjoint: assert property (@(posedge clk) disable iff (rst)
        (we_lo && we_hi) |-> (widx_lo != widx_hi));
endmodule

// File: rtl/pcbus_lane_front.sv
module pcbus_lane_front
    import pcbus_pkg::*;
#(
    parameter int         ATTR_BYTES = 256,
    parameter int         CIS_BYTES  = 128,
    parameter int         TF_REGS    = 8,
    parameter logic [7:0] INV_BYTE   = 8'hFF,
    parameter int         ADDR_W     = $clog2(ATTR_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spc_n,
    input  logic              cs_lo_n,
    input  logic              cs_hi_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_rd_n,
    input  logic              mem_wr_n,
    input  logic              io_rd_n,
    input  logic              io_wr_n,
    input  logic [15:0]       hd_in,
    output logic [15:0]       hd_out,
    output logic              lane_lo_en,
    output logic              lane_hi_en
);
    localparam int AIW = $clog2(ATTR_BYTES);
    localparam int TIW = $clog2(TF_REGS);

    typedef struct packed {
        target_e           tgt;
        lane_mode_e        mode;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       data;
    } wreq_t;

    access_t acc;
    wreq_t   wq;
    logic    wr_low_q, commit;
    logic    attr_we, tf_commit, tf_we_lo, tf_we_hi;
    logic [7:0] attr_rd, tf_rd_lo, tf_rd_hi, lo_byte, hi_byte;
    logic [TIW-1:0] r_idx_lo, w_idx_lo;

    pcbus_decode u_dec (
        .spc_n(spc_n), .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .acc(acc)
    );

    // write capture: track the low phase, commit on the rise
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_low_q <= 1'b0;
            wq       <= '0;
        end else begin
            wr_low_q <= acc.wr;
            if (acc.wr)
                wq <= '{tgt: acc.tgt, mode: acc.mode, addr: addr, data: hd_in};
        end
    end

    assign commit    = wr_low_q && !acc.wr;
    assign attr_we   = commit && wq.tgt == TG_ATTR
                     && ((wq.mode == LM_BYTE && !wq.addr[0]) || wq.mode == LM_WORD);
    assign tf_commit = commit && (wq.tgt == TG_TF_IO || wq.tgt == TG_TF_MEM);
    assign tf_we_lo  = tf_commit && (wq.mode == LM_BYTE || wq.mode == LM_WORD);
    assign tf_we_hi  = tf_commit && (wq.mode == LM_WORD || wq.mode == LM_ODD);
    assign w_idx_lo  = (wq.mode == LM_BYTE) ? wq.addr[TIW-1:0]
                                            : {wq.addr[TIW-1:1], 1'b0};
    assign r_idx_lo  = (acc.mode == LM_BYTE) ? addr[TIW-1:0]
                                             : {addr[TIW-1:1], 1'b0};

    pcbus_attr_space #(.ATTR_BYTES(ATTR_BYTES), .CIS_BYTES(CIS_BYTES), .IW(AIW)) u_attr (
        .clk(clk), .rst(rst), .we(attr_we), .widx(wq.addr[AIW:1]),
        .wdata(wq.data[7:0]), .ridx(addr[AIW:1]), .rdata(attr_rd)
    );

    pcbus_taskfile #(.TF_REGS(TF_REGS), .IW(TIW)) u_tf (
        .clk(clk), .rst(rst),
        .we_lo(tf_we_lo), .widx_lo(w_idx_lo), .wd_lo(wq.data[7:0]),
        .we_hi(tf_we_hi), .widx_hi({wq.addr[TIW-1:1], 1'b1}), .wd_hi(wq.data[15:8]),
        .ridx_lo(r_idx_lo), .ridx_hi({addr[TIW-1:1], 1'b1}),
        .rd_lo(tf_rd_lo), .rd_hi(tf_rd_hi)
    );

    // read lane steering
    always_comb begin
        lane_lo_en = acc.rd && (acc.mode == LM_BYTE || acc.mode == LM_WORD);
        lane_hi_en = acc.rd && (acc.mode == LM_WORD || acc.mode == LM_ODD);
        if (acc.tgt == TG_ATTR) begin
            lo_byte = (acc.mode == LM_BYTE && addr[0]) ? INV_BYTE : attr_rd;
            hi_byte = INV_BYTE;
        end else begin
            lo_byte = tf_rd_lo;
            hi_byte = tf_rd_hi;
        end
        hd_out = {lane_hi_en ? hi_byte : 8'h00, lane_lo_en ? lo_byte : 8'h00};
    end

    // R1: standby keeps both lanes off
    a_r1_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        (cs_lo_n && cs_hi_n) |-> (!lane_lo_en && !lane_hi_en));
    // R1: two standby samples in a row leave nothing to commit
    a_r1_standby_nowrite: assert property (@(posedge clk) disable iff (rst)
        (cs_lo_n && cs_hi_n && $past(cs_lo_n && cs_hi_n)) |-> !commit);
    // R2: byte mode uses the low lane only
    a_r2_byte_low_only: assert property (@(posedge clk) disable iff (rst)
        (!cs_lo_n && cs_hi_n && acc.rd) |-> (lane_lo_en && !lane_hi_en));
    // R4: odd-byte mode uses the high lane only
    a_r4_odd_high_only: assert property (@(posedge clk) disable iff (rst)
        (cs_lo_n && !cs_hi_n && acc.rd) |-> (lane_hi_en && !lane_lo_en));
    // R5: the high lane of any attribute read is the invalid value
    a_r5_attr_high_invalid: assert property (@(posedge clk) disable iff (rst)
        (!spc_n && !mem_rd_n && io_rd_n && io_wr_n && lane_hi_en)
            |-> (hd_out[15:8] == INV_BYTE));
    // R10: a strobe pulse commits only once
    a_r10_single_commit: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);
    // R11: memory and I/O read strobes together disable both lanes
    a_r11_clash_quiet: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_n && !io_rd_n) |-> (!lane_lo_en && !lane_hi_en));
endmodule

// File: tb/pcbus_lane_front_tb.sv
module pcbus_lane_front_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spc_n = 1'b0, cs_lo_n = 1'b1, cs_hi_n = 1'b1;
    logic [8:0] addr = '0;
    logic       mem_rd_n = 1'b1, mem_wr_n = 1'b1, io_rd_n = 1'b1, io_wr_n = 1'b1;
    logic [15:0] hd_in = '0;
    logic [15:0] hd_out;
    logic       lane_lo_en, lane_hi_en;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [17:0] got;

    always #10 clk = ~clk;

    pcbus_lane_front u_dut (
        .clk(clk), .rst(rst), .spc_n(spc_n), .cs_lo_n(cs_lo_n), .cs_hi_n(cs_hi_n),
        .addr(addr), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .hd_in(hd_in),
        .hd_out(hd_out), .lane_lo_en(lane_lo_en), .lane_hi_en(lane_hi_en)
    );

    // {spc_n, cs_hi_n, cs_lo_n, io, addr[9:0], lo_en, hi_en, lo, hi}
    localparam int NV = 11;
    localparam logic [31:0] VEC [NV] = '{
        {1'b0,1'b1,1'b0,1'b0,10'h000,1'b1,1'b0,8'h11,8'h00}, // R2 R5 attr byte 0
        {1'b0,1'b1,1'b0,1'b0,10'h001,1'b1,1'b0,8'hFF,8'h00}, // R5 odd address
        {1'b0,1'b0,1'b0,1'b0,10'h004,1'b1,1'b1,8'h17,8'hFF}, // R3 R5 attr word
        {1'b0,1'b0,1'b1,1'b0,10'h004,1'b0,1'b1,8'h00,8'hFF}, // R4 R5 attr odd mode
        {1'b0,1'b1,1'b0,1'b1,10'h003,1'b1,1'b0,8'hA3,8'h00}, // R7 R9 io byte
        {1'b0,1'b0,1'b0,1'b1,10'h005,1'b1,1'b1,8'hA4,8'hA5}, // R3 R9 io word, A0 ignored
        {1'b1,1'b1,1'b0,1'b0,10'h006,1'b1,1'b0,8'hA6,8'h00}, // R8 mem byte
        {1'b1,1'b0,1'b1,1'b0,10'h002,1'b0,1'b1,8'h00,8'hA3}, // R4 R8 mem odd mode
        {1'b0,1'b1,1'b1,1'b1,10'h000,1'b0,1'b0,8'h00,8'h00}, // R1 standby
        {1'b0,1'b1,1'b0,1'b0,10'h190,1'b1,1'b0,8'h00,8'h00}, // R6 writable byte 200
        {1'b0,1'b1,1'b0,1'b0,10'h0FE,1'b1,1'b0,8'h8E,8'h00}  // R6 last CIS byte
    };

    task automatic chk(input string req, input logic [31:0] g, input logic [31:0] e);
        checks++;
        if (g !== e) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, g, e);
        end
    endtask

    task automatic idle();
        mem_rd_n = 1'b1; mem_wr_n = 1'b1; io_rd_n = 1'b1; io_wr_n = 1'b1;
        cs_lo_n = 1'b1; cs_hi_n = 1'b1;
    endtask

    task automatic rd(input logic s, input logic ch, input logic cl, input logic io,
                      input logic [8:0] a);
        @(negedge clk);
        spc_n = s; cs_hi_n = ch; cs_lo_n = cl; addr = a;
        if (io) io_rd_n = 1'b0; else mem_rd_n = 1'b0;
        #5;
        got = {lane_lo_en, lane_hi_en, hd_out};
        idle();
    endtask

    task automatic wr(input logic s, input logic ch, input logic cl, input logic io,
                      input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        spc_n = s; cs_hi_n = ch; cs_lo_n = cl; addr = a; hd_in = d;
        if (io) io_wr_n = 1'b0; else mem_wr_n = 1'b0;
        @(negedge clk);
        io_wr_n = 1'b1; mem_wr_n = 1'b1;
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset state
        #1 chk("R1 idle lanes off", {30'd0, lane_lo_en, lane_hi_en}, 32'd0);
        rd(1'b0, 1'b1, 1'b0, 1'b1, 9'd0);
        chk("R9 task file reset", {14'd0, got}, {14'd0, 2'b10, 16'h0000});
        rd(1'b0, 1'b1, 1'b0, 1'b0, 9'd2);
        chk("R6 CIS reset byte 1", {14'd0, got}, {14'd0, 2'b10, 16'h0014});

        // load task file through I/O byte writes (R7)
        for (int i = 0; i < 8; i++)
            wr(1'b0, 1'b1, 1'b0, 1'b1, 9'(i), {8'h00, 8'(8'hA0 + i)});

        for (int v = 0; v < NV; v++) begin
            logic [31:0] e;
            e = VEC[v];
            rd(e[31], e[30], e[29], e[28], e[26:18]);
            chk($sformatf("vec %0d lane enables (R1-table)", v),
                {30'd0, got[17:16]}, {30'd0, e[17:16]});
            if (e[17]) chk($sformatf("vec %0d low lane R2 R3", v), {24'd0, got[7:0]}, {24'd0, e[15:8]});
            if (e[16]) chk($sformatf("vec %0d high lane R3 R4", v), {24'd0, got[15:8]}, {24'd0, e[7:0]});
        end

        // R6: protected byte ignores writes, byte above the boundary accepts them
        wr(1'b0, 1'b1, 1'b0, 1'b0, 9'd10, 16'h005A);
        rd(1'b0, 1'b1, 1'b0, 1'b0, 9'd10);
        chk("R6 CIS write ignored", {24'd0, got[7:0]}, 32'h20);
        wr(1'b0, 1'b1, 1'b0, 1'b0, 9'h190, 16'h005A);
        rd(1'b0, 1'b1, 1'b0, 1'b0, 9'h190);
        chk("R6 writable byte", {24'd0, got[7:0]}, 32'h5A);

        // R5: odd-address and odd-mode attribute writes change nothing
        wr(1'b0, 1'b1, 1'b0, 1'b0, 9'h191, 16'h0077);
        wr(1'b0, 1'b0, 1'b1, 1'b0, 9'h190, 16'h6600);
        rd(1'b0, 1'b1, 1'b0, 1'b0, 9'h190);
        chk("R5 odd attribute writes ignored", {24'd0, got[7:0]}, 32'h5A);

        // R8 R3: memory-mapped word write, read back through I/O
        wr(1'b1, 1'b0, 1'b0, 1'b0, 9'd3, 16'hBEEF);
        rd(1'b0, 1'b0, 1'b0, 1'b1, 9'd2);
        chk("R8 R3 word pair via other mapping", {14'd0, got}, {14'd0, 2'b11, 16'hBEEF});

        // R4: odd-mode write stores only the high byte into the odd register
        wr(1'b0, 1'b0, 1'b1, 1'b1, 9'd6, 16'h3C99);
        rd(1'b0, 1'b0, 1'b0, 1'b1, 9'd6);
        chk("R4 odd write", {14'd0, got}, {14'd0, 2'b11, 16'h3CA6});

        // R1: standby write commits nothing
        wr(1'b0, 1'b1, 1'b1, 1'b1, 9'd0, 16'h0099);
        rd(1'b0, 1'b1, 1'b0, 1'b1, 9'd0);
        chk("R1 standby write ignored", {24'd0, got[7:0]}, 32'hA0);

        // R11: clash read and clash write
        @(negedge clk);
        spc_n = 1'b0; cs_hi_n = 1'b1; cs_lo_n = 1'b0; addr = 9'd1;
        mem_rd_n = 1'b0; io_rd_n = 1'b0;
        #5 chk("R11 clash read lanes off", {30'd0, lane_lo_en, lane_hi_en}, 32'd0);
        idle();
        @(negedge clk);
        spc_n = 1'b0; cs_hi_n = 1'b1; cs_lo_n = 1'b0; addr = 9'd1; hd_in = 16'h0055;
        mem_wr_n = 1'b0; io_wr_n = 1'b0;
        @(negedge clk);
        mem_wr_n = 1'b1; io_wr_n = 1'b1;
        @(negedge clk) idle();
        rd(1'b0, 1'b1, 1'b0, 1'b1, 9'd1);
        chk("R11 clash write ignored", {24'd0, got[7:0]}, 32'hA1);

        // R10: data changing while the strobe is low; last low sample wins
        @(negedge clk);
        spc_n = 1'b0; cs_hi_n = 1'b1; cs_lo_n = 1'b0; addr = 9'd1; hd_in = 16'h0012;
        io_wr_n = 1'b0;
        @(negedge clk) hd_in = 16'h0034;
        @(negedge clk) io_wr_n = 1'b1;
        @(negedge clk) idle();
        rd(1'b0, 1'b1, 1'b0, 1'b1, 9'd1);
        chk("R10 last low data committed", {24'd0, got[7:0]}, 32'h34);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule